// File: doc/BRIEF.md
# Bit Field Execution Unit

This unit performs one bit field operation per request on a 32-bit operand. A field is chosen by a start offset and a width. The offset counts from the most significant bit. A width code of zero selects a full 32-bit field. A field that would run past bit 0 is cut short there, and the bits it keeps are its effective width.

The unit supports the following operations:
- zero-extending extract and sign-extending extract
- insert of a supplied value
- search for the first set bit inside the field
- non-destructive field test
- field test followed by set, clear or invert
- single-bit set, clear, invert and test
- scan of the whole operand for its first set bit

The negative and zero flags always describe the selected bits as they were before any change. This means a test-then-modify sequence returns the old state and the new word in the same response. Every result is registered. A request presented with a valid strobe is answered on the next clock edge.

Top module: `bfu_top`

## Requirements
- R1: The field covers the bits from position 31-offset downward, counting effective width bits. The width code 0 means 32. The effective width is the requested width, limited to 32-offset so that the field stops at bit 0.
- R2: Op code 0 returns the field right-justified and zero-extended on `ext_val`. Op code 1 returns it sign-extended from the field's top bit.
- R3: Op code 2 (insert) writes the low effective-width bits of `ins_val` into the field on `result`. All other bits keep their value.
- R4: Op code 3 (find first one) returns on `pos` the offset from the MSB of the first set bit in the field, searching from the field's MSB side. When the field is all zero it returns offset plus effective width and sets `flag_z`.
- R5: For every op, `flag_n` equals the field's most significant bit and `flag_z` is 1 exactly when all field bits are 0. Both are taken before any modification.
- R6: Op code 4 (field test) and every code above 12 leave `result` equal to the operand.
- R7: Op codes 5, 6 and 7 set all field bits to 1, clear them, or invert them, in that order.
- R8: Op codes 8, 9 and 10 set, clear or invert the single bit at position 31-offset, and op code 11 only tests it. For all four ops the width input is ignored and `flag_z` is the inverse of the prior bit value.
- R9: Op code 12 scans the whole operand. `pos` is the offset from the MSB of its first set bit, or 32 if the operand is zero.
- R10: Outputs update one clock after a request with `in_valid` high, and `out_valid` marks that cycle. After a synchronous reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Operation code |
| operand | input | 32 | Word operated on |
| ins_val | input | 32 | Value for insert |
| offset | input | 5 | Field start, counted from the MSB |
| width | input | 5 | Field width code, 0 means 32 |
| out_valid | output | 1 | Response strobe |
| result | output | 32 | Operand after the operation |
| ext_val | output | 32 | Extracted field value |
| pos | output | 6 | Found position, counted from the MSB |
| flag_n | output | 1 | Field most significant bit |
| flag_z | output | 1 | Field all zero |

## Verification
Extraction is tried with a field whose top bit is clear and one whose top bit is set. This separates zero extension from sign extension. Fields are placed mid-word, against bit 0 with truncation, and at the full width of 32, which exercises every branch of the width and offset arithmetic. The test-then-modify ops run on all-zero, all-one and mixed fields, and their flags are compared with the value before the change. The first-one search and the scan are run on an empty region and on regions whose first set bit lies at the edge or inside, so that the not-found position can be told apart from a real hit.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  typedef enum logic [3:0] {
    OP_EXTU  = 4'd0,
    OP_EXTS  = 4'd1,
    OP_INS   = 4'd2,
    OP_FFO   = 4'd3,
    OP_TST   = 4'd4,
    OP_TSET  = 4'd5,
    OP_TCLR  = 4'd6,
    OP_TCHG  = 4'd7,
    OP_BSET  = 4'd8,
    OP_BCLR  = 4'd9,
    OP_BCHG  = 4'd10,
    OP_BTST  = 4'd11,
    OP_BSCAN = 4'd12
  } bfu_op_e;
endpackage

// File: rtl/bfu_mask.sv
module bfu_mask #(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W),
  localparam int POS_W = IDX_W + 1
) (
  input  logic [IDX_W-1:0]  off,
  input  logic [IDX_W-1:0]  wcode,
  output logic [DATA_W-1:0] mask,
  output logic [IDX_W-1:0]  low,
  output logic [IDX_W-1:0]  msb,
  output logic [POS_W-1:0]  we
);
  logic [POS_W-1:0] req, room;

  always_comb begin
    req  = (wcode == '0) ? POS_W'(DATA_W) : {1'b0, wcode};
    room = POS_W'(DATA_W) - {1'b0, off};
    we   = (req < room) ? req : room;
    msb  = IDX_W'(DATA_W - 1) - off;
    low  = IDX_W'(room - we);
    for (int i = 0; i < DATA_W; i++) begin
      mask[i] = (IDX_W'(i) >= low) && (IDX_W'(i) <= msb);
    end
  end
endmodule

// File: rtl/bfu_first_one.sv
module bfu_first_one #(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] vec,
  output logic              found,
  output logic [IDX_W-1:0]  hi
);
  always_comb begin
    found = 1'b0;
    hi    = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (vec[i]) begin
        found = 1'b1;
        hi    = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/bfu_top.sv
module bfu_top
  import bfu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W),
  localparam int POS_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] ins_val,
  input  logic [IDX_W-1:0]  offset,
  input  logic [IDX_W-1:0]  width,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] ext_val,
  output logic [POS_W-1:0]  pos,
  output logic              flag_n,
  output logic              flag_z
);
  bfu_op_e          opc;
  logic [IDX_W-1:0] r_off, r_w;
  logic [DATA_W-1:0] mask, field, ufield, ones_hi, ext_c, res_c;
  logic [IDX_W-1:0] low, msb, hi;
  logic [POS_W-1:0] we, pos_c;
  logic             found, fn, fz, is_mod;

  assign opc = bfu_op_e'(op);

  // region select: single-bit ops use width 1, scan uses the whole word
  always_comb begin
    r_off = offset;
    r_w   = width;
    case (opc)
      OP_BSET, OP_BCLR, OP_BCHG, OP_BTST: r_w = IDX_W'(1);
      OP_BSCAN: begin r_off = '0; r_w = '0; end
      default: ;
    endcase
  end

  bfu_mask #(.DATA_W(DATA_W)) u_mask (
    .off(r_off), .wcode(r_w), .mask(mask), .low(low), .msb(msb), .we(we)
  );

  assign field = operand & mask;

  bfu_first_one #(.DATA_W(DATA_W)) u_ffo (
    .vec(field), .found(found), .hi(hi)
  );

  always_comb begin
    fn      = operand[msb];
    fz      = (field == '0);
    ufield  = field >> low;
    ones_hi = {DATA_W{1'b1}} << we;
    ext_c   = (opc == OP_EXTS && fn) ? (ufield | ones_hi) : ufield;
    pos_c   = found ? (POS_W'(DATA_W - 1) - {1'b0, hi}) : ({1'b0, r_off} + we);
    is_mod  = 1'b1;
    case (opc)
      OP_INS:           res_c = (operand & ~mask) | ((ins_val << low) & mask);
      OP_TSET, OP_BSET: res_c = operand | mask;
      OP_TCLR, OP_BCLR: res_c = operand & ~mask;
      OP_TCHG, OP_BCHG: res_c = operand ^ mask;
      default: begin res_c = operand; is_mod = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      ext_val   <= '0;
      pos       <= '0;
      flag_n    <= 1'b0;
      flag_z    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= res_c;
        ext_val <= ext_c;
        pos     <= pos_c;
        flag_n  <= fn;
        flag_z  <= fz;
      end
    end
  end

  // R10
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_valid && !rst));

  // R6
  keep_word_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(!is_mod) |-> result == $past(operand));

  // R3
  outside_field_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((result ^ $past(operand)) & ~$past(mask)) == '0);

  // R7
  set_fill_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(opc == OP_TSET) |-> (result & $past(mask)) == $past(mask));

  // R4
  miss_pos_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && flag_z && $past(opc == OP_FFO) |-> pos == $past({1'b0, r_off} + we));
endmodule

// File: tb/bfu_top_test.sv
module bfu_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic [31:0] operand = '0, ins_val = '0;
  logic [4:0]  offset = '0, width = '0;
  logic        out_valid, flag_n, flag_z;
  logic [31:0] result, ext_val;
  logic [5:0]  pos;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  bfu_top uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .operand(operand),
    .ins_val(ins_val), .offset(offset), .width(width), .out_valid(out_valid),
    .result(result), .ext_val(ext_val), .pos(pos), .flag_n(flag_n), .flag_z(flag_z)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // independent bit-serial model, walking the field from its MSB side
  task automatic model(input logic [3:0] o_p, input logic [31:0] a, input logic [31:0] ins,
                       input logic [4:0] off, input logic [4:0] wc,
                       output logic [31:0] res, output logic [31:0] ext,
                       output logic [5:0] p, output logic n, output logic z);
    int o, w, b;
    logic first;
    o = off;
    w = (wc == 0) ? 32 : int'(wc);
    if (o_p >= 8 && o_p <= 11) w = 1;
    if (o_p == 12) begin o = 0; w = 32; end
    if (o + w > 32) w = 32 - o;
    res = a; ext = '0; p = 6'(o + w); first = 1'b0;
    for (int k = 0; k < w; k++) begin
      b = 31 - (o + k);
      ext = {ext[30:0], a[b]};
      if (a[b] && !first) begin p = 6'(o + k); first = 1'b1; end
      case (o_p)
        4'd2: res[b] = ins[w-1-k];
        4'd5, 4'd8: res[b] = 1'b1;
        4'd6, 4'd9: res[b] = 1'b0;
        4'd7, 4'd10: res[b] = ~a[b];
        default: ;
      endcase
    end
    n = a[31-o];
    z = !first;
    if (o_p == 4'd1 && n) for (int k = w; k < 32; k++) ext[k] = 1'b1;
  endtask

  task automatic run(input string tag, input logic [3:0] o_p, input logic [31:0] a,
                     input logic [31:0] ins, input logic [4:0] off, input logic [4:0] wc);
    logic [31:0] er, ee; logic [5:0] ep; logic en, ez;
    @(negedge clk);
    op = o_p; operand = a; ins_val = ins; offset = off; width = wc; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    model(o_p, a, ins, off, wc, er, ee, ep, en, ez);
    chk({tag, " R10 valid"}, {31'd0, out_valid}, 32'd1);
    chk({tag, " result"}, result, er);
    chk({tag, " ext"}, ext_val, ee);
    chk({tag, " pos"}, {26'd0, pos}, {26'd0, ep});
    chk({tag, " R5 flags"}, {30'd0, flag_n, flag_z}, {30'd0, en, ez});
  endtask

  task automatic t_reset;
    chk("R10 reset valid", {31'd0, out_valid}, 32'd0);
    chk("R10 reset result", result, 32'd0);
    chk("R10 reset flags", {30'd0, flag_n, flag_z}, 32'd0);
  endtask

  task automatic t_extract;
    run("R2 extu mid", 4'd0, 32'h12345678, 0, 5'd4, 5'd8);
    chk("R2 extu literal", ext_val, 32'h23);
    run("R2 exts neg", 4'd1, 32'hF000_0000, 0, 5'd0, 5'd4);
    chk("R2 exts literal", ext_val, 32'hFFFF_FFFF);
    run("R2 exts pos", 4'd1, 32'h7000_0000, 0, 5'd0, 5'd4);
    run("R1 full width", 4'd1, 32'h8000_0001, 0, 5'd0, 5'd0);
    run("R1 truncated", 4'd0, 32'h0000_000A, 0, 5'd28, 5'd8);
    chk("R1 trunc literal", ext_val, 32'hA);
  endtask

  task automatic t_insert;
    run("R3 insert", 4'd2, 32'hFFFF_FFFF, 32'h0, 5'd8, 5'd8);
    chk("R3 insert literal", result, 32'hFF00_FFFF);
    run("R3 insert wide val", 4'd2, 32'h0, 32'hFFFF_FFA5, 5'd12, 5'd8);
    run("R3 insert trunc", 4'd2, 32'h1234_5678, 32'hF, 5'd30, 5'd6);
  endtask

  task automatic t_ffo;
    run("R4 ffo hit", 4'd3, 32'h0001_0000, 0, 5'd0, 5'd0);
    chk("R4 ffo literal", {26'd0, pos}, 32'd15);
    run("R4 ffo miss", 4'd3, 32'hFF00_00FF, 0, 5'd8, 5'd16);
    chk("R4 ffo miss pos", {26'd0, pos}, 32'd24);
    run("R4 ffo trunc miss", 4'd3, 32'h0, 0, 5'd28, 5'd8);
    chk("R4 ffo trunc literal", {26'd0, pos}, 32'd32);
    run("R4 ffo edge", 4'd3, 32'h0080_0000, 0, 5'd8, 5'd4);
  endtask

  task automatic t_testmod;
    run("R6 test", 4'd4, 32'hDEAD_BEEF, 0, 5'd4, 5'd12);
    run("R6 undefined op", 4'd14, 32'hDEAD_BEEF, 32'h1, 5'd0, 5'd8);
    run("R7 tset zero", 4'd5, 32'h0, 0, 5'd4, 5'd8);
    chk("R7 tset literal", result, 32'h0FF0_0000);
    run("R7 tclr ones", 4'd6, 32'hFFFF_FFFF, 0, 5'd16, 5'd0);
    run("R7 tchg mixed", 4'd7, 32'hA5A5_A5A5, 0, 5'd2, 5'd20);
  endtask

  task automatic t_bitops;
    run("R8 bset", 4'd8, 32'h0, 0, 5'd31, 5'd9);
    chk("R8 bset literal", result, 32'h1);
    run("R8 bclr", 4'd9, 32'hFFFF_FFFF, 0, 5'd0, 5'd3);
    run("R8 bchg", 4'd10, 32'h0000_0400, 0, 5'd21, 5'd0);
    run("R8 btst", 4'd11, 32'h0, 0, 5'd5, 5'd17);
    chk("R8 btst z", {31'd0, flag_z}, 32'd1);
  endtask

  task automatic t_scan;
    run("R9 scan zero", 4'd12, 32'h0, 0, 5'd7, 5'd3);
    chk("R9 scan none", {26'd0, pos}, 32'd32);
    run("R9 scan hit", 4'd12, 32'h0000_0003, 0, 5'd9, 5'd1);
    chk("R9 scan literal", {26'd0, pos}, 32'd30);
  endtask

  task automatic finish_up;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_extract();
    t_insert();
    t_ffo();
    t_testmod();
    t_bitops();
    t_scan();
    finish_up();
  end
endmodule